// File: doc/BRIEF.md
# TLB Test Port: Register-Driven Entry Install and Probe

This block is a 32-entry translation lookaside buffer arranged as eight sets of four ways. It is reached only through two 32-bit test registers: a control register and a data register. Software writes the registers and then pulses a command strobe.

A control register whose command bit is 0 installs an entry. The tag comes from the control register and the physical page number comes from the data register. A command bit of 1 probes the buffer. The probe writes the matching entry's physical page number, a hit flag, the hitting way and the set's replacement bits into the data register.

Each stored attribute (dirty, user, writable) is matched through a pair of request bits that acts as a mask. A pair can therefore demand a 1, demand a 0, or accept either value. Victim choice on install uses a three-bit tree pseudo-LRU per set, unless software names the way explicitly.

Top module: `tlbt_top`

## Requirements
- R1: After synchronous reset, both registers read zero and `done` is low. Every entry is invalid with a zero tag, and every set's LRU bits are zero, so a probe with valid request bit 1 misses.
- R2: Control register layout: page number in bits 31:12, valid request in bit 11, attribute pairs (D, D#) in 10:9, (U, U#) in 8:7 and (R, R#) in 6:5, command in bit 0. Bits 4:1 read zero. Data register layout: page number in 31:12, LRU in 9:7, hit flag in 4, way field in 3:2. Bits 11:10, 6:5 and 1:0 read zero.
- R3: An install (command 0) stores the following into the chosen way of the set selected by control bits 14:12: tag = control bits 31:15, valid = bit 11, and each stored attribute equal to the first bit of its pair (bits 10, 8, 6). The stored page number is data bits 31:12. An install leaves the data register unchanged.
- R4: On install, the way is data bits 3:2 when data bit 4 is 1. Otherwise the way is the tree victim: if LRU bit 7 is 0, the way is 0 or 1 as given by bit 8; if bit 7 is 1, the way is 2 or 3 as given by bit 9.
- R5: A probe (command 1) matches an entry of the selected set whose stored tag equals control bits 31:15 and whose valid bit equals control bit 11. Each attribute must also pass its pair: stored 1 needs the first bit set, and stored 0 needs the second bit set. When several ways match, the lowest-numbered way wins.
- R6: On a probe hit, the data register gets the entry's page number, hit flag 1, the way number, and the set's LRU bits as they were before the command.
- R7: On a probe miss, the data register gets page number 0, hit flag 0, way 0, and the set's current LRU bits.
- R8: Every install and every probe hit touches the used way in the set's LRU. Touching way 0 or 1 sets bit 7 and sets bit 8 to the inverse of the way's low bit. Touching way 2 or 3 clears bit 7 and sets bit 9 to the inverse of the way's low bit. A probe miss leaves the LRU unchanged.
- R9: `done` is high for exactly one cycle, the cycle after each `cmd_go`. Probe results are readable on `dat_q` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 32 | Control register write value |
| dat_we | input | 1 | Write strobe for the data register |
| dat_wdata | input | 32 | Data register write value |
| cmd_go | input | 1 | Execute the command held in the control register |
| ctl_q | output | 32 | Control register contents |
| dat_q | output | 32 | Data register contents |
| done | output | 1 | One-cycle command completion strobe |

## Verification
The hardest situation to reach from the ports is a set in which two ways hold the same tag. The pseudo-LRU path never installs a duplicate by itself. The stimulus therefore uses the explicit way field to place one tag in ways 3 and 1, and then probes to confirm that the lower way wins. Filling a set through the victim path is also indirect, because each choice depends on the touch history. The bench fills one set with four victim-chosen installs and checks the exact way order 0, 2, 1, 3. A random phase confined to two sets then mixes installs, forced-way installs and masked probes against a scoreboard model.

// File: rtl/tlbt_pkg.sv
package tlbt_pkg;

    localparam int WAYS   = 4;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int SETS   = 8;
    localparam int SET_W  = $clog2(SETS);
    localparam int PAGE_W = 20;
    localparam int TAG_W  = PAGE_W - SET_W;
    localparam int LRU_W  = WAYS - 1;
    localparam int REG_W  = 32;

    typedef enum logic {
        CMD_INSTALL = 1'b0,
        CMD_PROBE   = 1'b1
    } cmd_e;

    typedef struct packed {
        logic x;
        logic xn;
    } apair_t;

    typedef struct packed {
        logic [PAGE_W-1:0] lpn;
        logic              valid;
        apair_t            d;
        apair_t            u;
        apair_t            r;
        logic [3:0]        rsv;
        cmd_e              cmd;
    } ctl_t;

    typedef struct packed {
        logic [PAGE_W-1:0] ppn;
        logic [1:0]        z_hi;
        logic [LRU_W-1:0]  lru;
        logic [1:0]        z_mid;
        logic              pl;
        logic [WAY_W-1:0]  rep;
        logic [1:0]        z_lo;
    } dat_t;

    typedef struct packed {
        logic [TAG_W-1:0]  vtag;
        logic              valid;
        logic              d;
        logic              u;
        logic              r;
        logic [PAGE_W-1:0] ppn;
    } entry_t;

    function automatic logic attr_ok(input logic stored, input apair_t p);
        return stored ? p.x : p.xn;
    endfunction

    function automatic logic [WAY_W-1:0] plru_victim(input logic [LRU_W-1:0] t);
        if (!t[0]) return {1'b0, t[1]};
        return {1'b1, t[2]};
    endfunction

    function automatic logic [LRU_W-1:0] plru_touch(input logic [LRU_W-1:0] t,
                                                     input logic [WAY_W-1:0] w);
        logic [LRU_W-1:0] n;
        n = t;
        if (!w[1]) begin
            n[0] = 1'b1;
            n[1] = ~w[0];
        end else begin
            n[0] = 1'b0;
            n[2] = ~w[0];
        end
        return n;
    endfunction

endpackage

// File: rtl/tlbt_regs.sv
module tlbt_regs
    import tlbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [REG_W-1:0] ctl_wdata,
    input  logic             dat_we,
    input  logic [REG_W-1:0] dat_wdata,
    input  logic             res_we,
    input  dat_t             res,
    output ctl_t             ctl,
    output dat_t             dat
);

    ctl_t ctl_in;
    dat_t dat_in;

    always_comb begin
        ctl_in     = ctl_t'(ctl_wdata);
        ctl_in.rsv = '0;
        dat_in       = dat_t'(dat_wdata);
        dat_in.z_hi  = '0;
        dat_in.z_mid = '0;
        dat_in.z_lo  = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (ctl_we) begin
            ctl <= ctl_in;
        end
    end

    // a command result takes precedence over a software write in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            dat <= '0;
        end else if (res_we) begin
            dat <= res;
        end else if (dat_we) begin
            dat <= dat_in;
        end
    end

endmodule

// File: rtl/tlbt_plru.sv
module tlbt_plru
    import tlbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_idx,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way,
    output logic [LRU_W-1:0] cur_lru,
    output logic [WAY_W-1:0] victim
);

    logic [LRU_W-1:0] lru_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
        end else if (touch_en) begin
            lru_q[set_idx] <= plru_touch(lru_q[set_idx], touch_way);
        end
    end

    assign cur_lru = lru_q[set_idx];
    assign victim  = plru_victim(cur_lru);

endmodule

// File: rtl/tlbt_store.sv
module tlbt_store
    import tlbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SET_W-1:0]  set_idx,
    input  logic [TAG_W-1:0]  key_tag,
    input  logic              key_valid,
    input  apair_t            key_d,
    input  apair_t            key_u,
    input  apair_t            key_r,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  entry_t            wr_entry,
    output logic              hit_any,
    output logic [WAY_W-1:0]  hit_way,
    output logic [PAGE_W-1:0] hit_ppn
);

    entry_t            arr [SETS][WAYS];
    logic [WAYS-1:0]   hit_vec;
    logic [PAGE_W-1:0] way_ppn [WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    arr[s][w] <= '0;
        end else if (wr_en) begin
            arr[set_idx][wr_way] <= wr_entry;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        entry_t e;
        assign e          = arr[set_idx][w];
        assign way_ppn[w] = e.ppn;
        assign hit_vec[w] = (e.valid == key_valid) && (e.vtag == key_tag)
                          && attr_ok(e.d, key_d) && attr_ok(e.u, key_u)
                          && attr_ok(e.r, key_r);
    end

    // lowest matching way wins
    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit_any = |hit_vec;
    assign hit_ppn = way_ppn[hit_way];

endmodule

// File: rtl/tlbt_top.sv
module tlbt_top
    import tlbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [REG_W-1:0] ctl_wdata,
    input  logic             dat_we,
    input  logic [REG_W-1:0] dat_wdata,
    input  logic             cmd_go,
    output logic [REG_W-1:0] ctl_q,
    output logic [REG_W-1:0] dat_q,
    output logic             done
);

    ctl_t              ctl;
    dat_t              dat;
    dat_t              res;
    logic [SET_W-1:0]  set_idx;
    logic              go_wr;
    logic              go_lk;
    logic              hit_any;
    logic [WAY_W-1:0]  hit_way;
    logic [PAGE_W-1:0] hit_ppn;
    logic [LRU_W-1:0]  cur_lru;
    logic [WAY_W-1:0]  victim;
    logic [WAY_W-1:0]  wr_way;
    logic              touch_en;
    logic [WAY_W-1:0]  touch_way;
    entry_t            wr_entry;
    logic              done_q;

    assign set_idx = ctl.lpn[SET_W-1:0];
    assign go_wr   = cmd_go && (ctl.cmd == CMD_INSTALL);
    assign go_lk   = cmd_go && (ctl.cmd == CMD_PROBE);
    assign wr_way  = dat.pl ? dat.rep : victim;

    assign touch_en  = go_wr || (go_lk && hit_any);
    assign touch_way = go_wr ? wr_way : hit_way;

    always_comb begin
        wr_entry.vtag  = ctl.lpn[PAGE_W-1:SET_W];
        wr_entry.valid = ctl.valid;
        wr_entry.d     = ctl.d.x;
        wr_entry.u     = ctl.u.x;
        wr_entry.r     = ctl.r.x;
        wr_entry.ppn   = dat.ppn;
    end

    always_comb begin
        res       = '0;
        res.lru   = cur_lru;
        res.pl    = hit_any;
        res.ppn   = hit_any ? hit_ppn : '0;
        res.rep   = hit_any ? hit_way : '0;
    end

    tlbt_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .dat_we    (dat_we),
        .dat_wdata (dat_wdata),
        .res_we    (go_lk),
        .res       (res),
        .ctl       (ctl),
        .dat       (dat)
    );

    tlbt_store u_store (
        .clk       (clk),
        .rst       (rst),
        .set_idx   (set_idx),
        .key_tag   (ctl.lpn[PAGE_W-1:SET_W]),
        .key_valid (ctl.valid),
        .key_d     (ctl.d),
        .key_u     (ctl.u),
        .key_r     (ctl.r),
        .wr_en     (go_wr),
        .wr_way    (wr_way),
        .wr_entry  (wr_entry),
        .hit_any   (hit_any),
        .hit_way   (hit_way),
        .hit_ppn   (hit_ppn)
    );

    tlbt_plru u_plru (
        .clk       (clk),
        .rst       (rst),
        .set_idx   (set_idx),
        .touch_en  (touch_en),
        .touch_way (touch_way),
        .cur_lru   (cur_lru),
        .victim    (victim)
    );

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= cmd_go;
    end

    assign done  = done_q;
    assign ctl_q = ctl;
    assign dat_q = dat;

endmodule

// File: rtl/tlbt_chk.sv
module tlbt_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_go,
    input logic        dat_we,
    input logic        lookup_hit,
    input logic [31:0] ctl_q,
    input logic [31:0] dat_q,
    input logic        done
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!done && dat_q == 32'h0 && ctl_q == 32'h0));

    // R9
    done_follows_go_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_go |=> done);

    // R9
    done_only_after_go_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_go |=> !done);

    // R2
    ctl_rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q[4:1] == 4'h0);

    // R2
    dat_rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_q[11:10] == 2'b00) && (dat_q[6:5] == 2'b00) && (dat_q[1:0] == 2'b00));

    // R6
    hit_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_go && ctl_q[0] && lookup_hit) |=> dat_q[4]);

    // R7
    miss_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_go && ctl_q[0] && !lookup_hit) |=>
            (!dat_q[4] && dat_q[31:12] == 20'h0 && dat_q[3:2] == 2'b00));

    // R3
    install_keeps_dat_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_go && !ctl_q[0] && !dat_we) |=> $stable(dat_q));

endmodule

bind tlbt_top tlbt_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_go     (cmd_go),
    .dat_we     (dat_we),
    .lookup_hit (hit_any),
    .ctl_q      (ctl_q),
    .dat_q      (dat_q),
    .done       (done)
);

// File: tb/tb_tlbt_top.sv
`timescale 1ns/1ps
module tb_tlbt_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        dat_we = 1'b0;
    logic [31:0] dat_wdata = '0;
    logic        cmd_go = 1'b0;
    logic [31:0] ctl_q;
    logic [31:0] dat_q;
    logic        done;

    always #2 clk = ~clk;

    tlbt_top dut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .cmd_go(cmd_go),
        .ctl_q(ctl_q), .dat_q(dat_q), .done(done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    // reference model
    logic [16:0] m_tag [8][4];
    logic        m_v   [8][4];
    logic        m_d   [8][4];
    logic        m_u   [8][4];
    logic        m_r   [8][4];
    logic [19:0] m_ppn [8][4];
    logic [2:0]  m_lru [8];
    logic [31:0] m_ctl = '0;
    logic [31:0] m_dat = '0;

    function automatic logic [31:0] mk_ctl(input logic [19:0] lpn, input logic v,
        input logic [1:0] dp, input logic [1:0] up, input logic [1:0] rp, input logic c);
        return {lpn, v, dp, up, rp, 4'b0000, c};
    endfunction

    function automatic logic [31:0] mk_dat(input logic [19:0] ppn, input logic pl,
                                           input logic [1:0] rep);
        return {ppn, 2'b00, 3'b000, 2'b00, pl, rep, 2'b00};
    endfunction

    function automatic logic [1:0] victim_of(input logic [2:0] t);
        return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
    endfunction

    function automatic logic [2:0] touched(input logic [2:0] t, input logic [1:0] w);
        logic [2:0] n;
        n = t;
        if (w < 2) begin n[0] = 1'b1; n[1] = (w == 0); end
        else       begin n[0] = 1'b0; n[2] = (w == 2); end
        return n;
    endfunction

    function automatic logic pair_ok(input logic s, input logic [1:0] p);
        return s ? p[1] : p[0];
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [31:0] v);
        ctl_wdata = v; ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
        m_ctl = v & 32'hFFFF_FFE1;
    endtask

    task automatic wr_dat(input logic [31:0] v);
        dat_wdata = v; dat_we = 1'b1;
        @(negedge clk);
        dat_we = 1'b0;
        m_dat = v & 32'hFFFF_F39C;
    endtask

    // driver: computes the expected data register and queues it
    task automatic run_cmd(input string tag);
        item_t it;
        int s;
        logic hit;
        logic [1:0] hw;
        logic [1:0] w;
        s = int'(m_ctl[14:12]);
        if (!m_ctl[0]) begin
            w = m_dat[4] ? m_dat[3:2] : victim_of(m_lru[s]);
            m_tag[s][w] = m_ctl[31:15];
            m_v[s][w]   = m_ctl[11];
            m_d[s][w]   = m_ctl[10];
            m_u[s][w]   = m_ctl[8];
            m_r[s][w]   = m_ctl[6];
            m_ppn[s][w] = m_dat[31:12];
            m_lru[s]    = touched(m_lru[s], w);
        end else begin
            hit = 1'b0; hw = 2'd0;
            for (int k = 0; k < 4; k++) begin
                if (!hit && m_v[s][k] == m_ctl[11] && m_tag[s][k] == m_ctl[31:15]
                    && pair_ok(m_d[s][k], m_ctl[10:9]) && pair_ok(m_u[s][k], m_ctl[8:7])
                    && pair_ok(m_r[s][k], m_ctl[6:5])) begin
                    hit = 1'b1; hw = 2'(k);
                end
            end
            m_dat = {hit ? m_ppn[s][hw] : 20'h0, 2'b00, m_lru[s], 2'b00, hit,
                     hit ? hw : 2'b00, 2'b00};
            if (hit) m_lru[s] = touched(m_lru[s], hw);
        end
        it.exp = m_dat; it.tag = tag;
        sbq.push_back(it);
        cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
    endtask

    // monitor: pops and compares on every completion strobe
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R9 unexpected done", {31'b0, done}, 32'h0);
            end else begin
                item_t it;
                it = sbq.pop_front();
                check(dat_q === it.exp, it.tag, dat_q, it.exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int order [4] = '{0, 2, 1, 3};
        for (int s = 0; s < 8; s++) begin
            m_lru[s] = 3'b000;
            for (int w = 0; w < 4; w++) begin
                m_tag[s][w] = '0; m_v[s][w] = 1'b0; m_d[s][w] = 1'b0;
                m_u[s][w] = 1'b0; m_r[s][w] = 1'b0; m_ppn[s][w] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(ctl_q == 32'h0, "R1 ctl after reset", ctl_q, 32'h0);
        check(dat_q == 32'h0, "R1 dat after reset", dat_q, 32'h0);
        check(done == 1'b0, "R1 done after reset", {31'b0, done}, 32'h0);
        wr_ctl(mk_ctl(20'h12345, 1'b1, 2'b11, 2'b11, 2'b11, 1'b1));
        run_cmd("R1 probe of empty buffer misses");

        // R2 field masks
        wr_ctl(32'hFFFF_FFFE);
        check(ctl_q == 32'hFFFF_FFE0, "R2 ctl read-zero bits", ctl_q, 32'hFFFF_FFE0);
        wr_dat(32'hFFFF_FFFF);
        check(dat_q == 32'hFFFF_F39C, "R2 dat read-zero bits", dat_q, 32'hFFFF_F39C);

        // R4 fill set 3 through the tree victim: ways 0,2,1,3
        for (int k = 0; k < 4; k++) begin
            wr_dat(mk_dat(20'hA0000 + 20'(k), 1'b0, 2'b00));
            wr_ctl(mk_ctl({17'(k + 1), 3'd3}, 1'b1, 2'b10, 2'b10, 2'b10, 1'b0));
            run_cmd("R3 install keeps data register");
        end
        for (int k = 0; k < 4; k++) begin
            wr_ctl(mk_ctl({17'(k + 1), 3'd3}, 1'b1, 2'b11, 2'b11, 2'b11, 1'b1));
            run_cmd("R6 probe of victim-filled set");
            check(dat_q[3:2] == 2'(order[k]), "R4 victim way order", {30'b0, dat_q[3:2]},
                  32'(order[k]));
        end

        // R4 forced way overwrites way 2
        wr_dat(mk_dat(20'hBEEF0, 1'b1, 2'd2));
        wr_ctl(mk_ctl({17'd9, 3'd3}, 1'b1, 2'b10, 2'b01, 2'b10, 1'b0));
        run_cmd("R4 forced-way install");
        wr_ctl(mk_ctl({17'd2, 3'd3}, 1'b1, 2'b11, 2'b11, 2'b11, 1'b1));
        run_cmd("R7 overwritten tag misses");
        wr_ctl(mk_ctl({17'd9, 3'd3}, 1'b1, 2'b11, 2'b11, 2'b11, 1'b1));
        run_cmd("R4 forced-way tag hits");
        check(dat_q[3:2] == 2'd2 && dat_q[31:12] == 20'hBEEF0, "R4 forced way readback",
              dat_q, {20'hBEEF0, 12'h008});

        // R5 attribute masks: stored D=1 U=0 R=1 in set 5
        wr_dat(mk_dat(20'h55555, 1'b0, 2'b00));
        wr_ctl(mk_ctl({17'h1ABCD, 3'd5}, 1'b1, 2'b10, 2'b01, 2'b10, 1'b0));
        run_cmd("R3 install with attributes");
        wr_ctl(mk_ctl({17'h1ABCD, 3'd5}, 1'b1, 2'b10, 2'b01, 2'b10, 1'b1));
        run_cmd("R5 exact attribute match hits");
        wr_ctl(mk_ctl({17'h1ABCD, 3'd5}, 1'b1, 2'b11, 2'b11, 2'b10, 1'b1));
        run_cmd("R5 wildcard pair hits");
        wr_ctl(mk_ctl({17'h1ABCD, 3'd5}, 1'b1, 2'b01, 2'b01, 2'b10, 1'b1));
        run_cmd("R5 D demands zero misses");
        check(dat_q[4] == 1'b0, "R5 D mismatch flag", dat_q, 32'h0);
        wr_ctl(mk_ctl({17'h1ABCD, 3'd5}, 1'b1, 2'b10, 2'b01, 2'b00, 1'b1));
        run_cmd("R5 empty pair misses");
        wr_ctl(mk_ctl({17'h1ABCD, 3'd5}, 1'b0, 2'b11, 2'b11, 2'b11, 1'b1));
        run_cmd("R5 valid request 0 misses valid entry");
        wr_ctl(mk_ctl({17'h1ABCD, 3'd4}, 1'b1, 2'b11, 2'b11, 2'b11, 1'b1));
        run_cmd("R5 other set misses");

        // R5 duplicate tag in ways 3 and 1: lowest wins
        wr_dat(mk_dat(20'h33333, 1'b1, 2'd3));
        wr_ctl(mk_ctl({17'h00777, 3'd6}, 1'b1, 2'b01, 2'b01, 2'b01, 1'b0));
        run_cmd("R4 duplicate into way 3");
        wr_dat(mk_dat(20'h11111, 1'b1, 2'd1));
        run_cmd("R4 duplicate into way 1");
        wr_ctl(mk_ctl({17'h00777, 3'd6}, 1'b1, 2'b11, 2'b11, 2'b11, 1'b1));
        run_cmd("R5 lowest way wins");
        check(dat_q[3:2] == 2'd1, "R5 duplicate way", {30'b0, dat_q[3:2]}, 32'd1);

        // R8 random mix over two sets
        for (int i = 0; i < 300; i++) begin
            logic [19:0] lpn;
            logic [1:0]  pr [3];
            lpn = {17'($urandom_range(0, 5)), 3'($urandom_range(0, 1))};
            for (int p = 0; p < 3; p++) pr[p] = 2'($urandom_range(1, 3));
            if ($urandom_range(0, 2) == 0) begin
                wr_dat(mk_dat(20'($urandom), 1'($urandom_range(0, 1)),
                              2'($urandom_range(0, 3))));
                wr_ctl(mk_ctl(lpn, 1'($urandom_range(0, 7) != 0), pr[0] | 2'b10 & {2{pr[0][1]}},
                              pr[1], pr[2], 1'b0));
                run_cmd("R8 random install");
            end else begin
                wr_ctl(mk_ctl(lpn, 1'b1, pr[0], pr[1], pr[2], 1'b1));
                run_cmd("R8 random probe");
            end
        end

        repeat (3) @(negedge clk);
        check(sbq.size() == 0, "R9 all commands completed", 32'(sbq.size()), 32'h0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule